// File: doc/BRIEF.md
# Vertical Clock Pattern Group Selector

This block drives a bank of vertical clock lines for an image sensor. Each line's waveform over one horizontal line comes from a small store of programmable toggle patterns. A pixel counter restarts on every horizontal sync pulse. Each output level is a start polarity that is inverted at each programmed toggle position the counter passes.

Every output names one of four indirect group slots (A, B, C, D), and every slot names one stored pattern. Changing a slot's pattern index therefore re-targets all outputs on that slot at once. A merge mode joins the toggle positions of all four slots' patterns into one sequence per output, which gives up to sixteen toggles per line. Software loads all settings through a simple write port. The settings are held in a shadow copy and take effect at the next horizontal sync, so a line in progress is never disturbed.

Top module: `vpg_group_sel`

## Requirements
- R1: After reset every output is low. Every group select is slot A, every slot points to pattern 0, merge mode is off and all pattern words are zero. An output whose group select was never written follows slot A.
- R2: The group select for output o is at address 0x010+o. Bits 1:0 code the slot: 0=A, 1=B, 2=C, 3=D. In normal mode the output follows the pattern of that slot.
- R3: The slot pattern index for slot s (0=A to 3=D) is at address 0x004+s, in bits 1:0. Every output assigned to the slot follows the pattern that this index names.
- R4: Pattern words are at address 0x200 | p<<6 | o<<3 | k, for pattern p and output o. With k=0, bit 0 is the start polarity. With k=1 to 4, bits 11:0 are toggle position k-1. Writes with k=5 to 7 change nothing.
- R5: Address 0x000 bits 13:10 hold the merge field. A value of 1 merges the toggle positions of the patterns of all four slots for every output, takes the polarity from slot A and ignores the group select. Any other value selects normal mode.
- R6: Toggle positions that are equal count as one toggle. This holds within one pattern and across slots that name the same pattern, so duplicated slots never cancel each other.
- R7: In the edge that samples horizontal sync high, the counter restarts at 0 and every output loads its start polarity.
- R8: A toggle at position t inverts the output in the edge that comes t+1 edges after the edge that samples horizontal sync.
- R9: Writes do not affect the outputs until the next horizontal sync. A write in the same cycle as horizontal sync waits for the sync after that one.
- R10: The counter stops at 4095 and holds there. Position 4095 never fires. Before the first horizontal sync after reset, no output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync pulse, starts a line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 16 | Register write data |
| vout | output | 8 | Vertical clock outputs |

## Verification
Two events can land in the same edge: a register write and the horizontal sync that copies the shadow settings into the active set. The bench's random writes fall on any cycle of a line, including the sync cycle, so this case occurs many times. A bench model copies its shadow before it applies the write. Any output that then shows the new value one line early is a miscompare. A toggle position of 0 also coincides with the polarity reload at sync. Random positions produce this case, and the expected level is the polarity inverted one edge later.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
   localparam int SLOTS = 4;
   localparam int GSEL_W = 2;
   localparam int CAT_LSB = 10;
   localparam int CAT_W = 4;
   localparam logic [CAT_W-1:0] CAT_MERGE = 4'd1;
endpackage

// File: rtl/vpg_regs.sv
// Shadow and active configuration banks; the active bank loads on hsync.
module vpg_regs import vpg_pkg::*; #(
   parameter int NUM_OUT = 8,
   parameter int NUM_PAT = 4,
   parameter int NUM_TOG = 4,
   parameter int POS_W = 12,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   localparam int PID_W = $clog2(NUM_PAT),
   localparam int OUT_W = $clog2(NUM_OUT),
   localparam int TOG_W = $clog2(NUM_TOG),
   localparam int K_W = $clog2(NUM_TOG + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic hsync,
   input  logic wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic v_concat,
   output logic [PID_W-1:0] v_slot [SLOTS],
   output logic [NUM_OUT-1:0][GSEL_W-1:0] v_gsel,
   output logic [NUM_OUT-1:0] v_pol [NUM_PAT],
   output logic [NUM_OUT-1:0][NUM_TOG-1:0][POS_W-1:0] v_pos [NUM_PAT]
);
   localparam logic [PID_W:0] P_LIM = (PID_W+1)'(NUM_PAT);
   localparam logic [OUT_W:0] O_LIM = (OUT_W+1)'(NUM_OUT);
   localparam logic [4:0] G_LIM = 5'(NUM_OUT);

   logic shd_cat, act_cat;
   logic [PID_W-1:0] shd_slot [SLOTS];
   logic [PID_W-1:0] act_slot [SLOTS];
   logic [NUM_OUT-1:0][GSEL_W-1:0] shd_gsel, act_gsel;
   logic [NUM_OUT-1:0] shd_pol [NUM_PAT];
   logic [NUM_OUT-1:0] act_pol [NUM_PAT];
   logic [NUM_OUT-1:0][NUM_TOG-1:0][POS_W-1:0] shd_pos [NUM_PAT];
   logic [NUM_OUT-1:0][NUM_TOG-1:0][POS_W-1:0] act_pos [NUM_PAT];

   logic [K_W-1:0] f_k;
   logic [OUT_W-1:0] f_o;
   logic [PID_W-1:0] f_p;
   logic [TOG_W-1:0] f_t;
   logic [3:0] g_idx;
   logic ctrl_ok, slot_ok, gsel_ok, pat_ok;
   logic unused_bits;

   assign f_k = wr_addr[K_W-1:0];
   assign f_o = wr_addr[K_W +: OUT_W];
   assign f_p = wr_addr[K_W+OUT_W +: PID_W];
   assign f_t = TOG_W'(f_k - K_W'(1));
   assign g_idx = wr_addr[3:0];
   assign unused_bits = ^{wr_data, wr_addr};

   assign ctrl_ok = wr_en && (wr_addr == '0);
   assign slot_ok = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
   assign gsel_ok = wr_en && (wr_addr[ADDR_W-1:4] == (ADDR_W-4)'(1))
                    && ({1'b0, g_idx} < G_LIM);
   assign pat_ok  = wr_en && wr_addr[ADDR_W-1]
                    && ({1'b0, f_p} < P_LIM) && ({1'b0, f_o} < O_LIM);

   always_ff @(posedge clk) begin
      if (rst) begin
         shd_cat  <= 1'b0;
         act_cat  <= 1'b0;
         shd_slot <= '{default: '0};
         act_slot <= '{default: '0};
         shd_gsel <= '0;
         act_gsel <= '0;
         shd_pol  <= '{default: '0};
         act_pol  <= '{default: '0};
         shd_pos  <= '{default: '0};
         act_pos  <= '{default: '0};
      end else begin
         if (hsync) begin
            act_cat  <= shd_cat;
            act_slot <= shd_slot;
            act_gsel <= shd_gsel;
            act_pol  <= shd_pol;
            act_pos  <= shd_pos;
         end
         if (ctrl_ok)
            shd_cat <= (wr_data[CAT_LSB +: CAT_W] == CAT_MERGE);
         if (slot_ok)
            shd_slot[wr_addr[1:0]] <= wr_data[PID_W-1:0];
         if (gsel_ok)
            shd_gsel[OUT_W'(g_idx)] <= wr_data[GSEL_W-1:0];
         if (pat_ok) begin
            if (f_k == '0)
               shd_pol[f_p][f_o] <= wr_data[0];
            else if (f_k <= K_W'(NUM_TOG))
               shd_pos[f_p][f_o][f_t] <= wr_data[POS_W-1:0];
         end
      end
   end

   // During the sync cycle the lanes see the settings of the coming line.
   always_comb begin
      if (hsync) begin
         v_concat = shd_cat;
         v_slot   = shd_slot;
         v_gsel   = shd_gsel;
         v_pol    = shd_pol;
         v_pos    = shd_pos;
      end else begin
         v_concat = act_cat;
         v_slot   = act_slot;
         v_gsel   = act_gsel;
         v_pol    = act_pol;
         v_pos    = act_pos;
      end
   end
endmodule

// File: rtl/vpg_line_cnt.sv
// Pixel counter: cleared by hsync, saturates at all-ones.
module vpg_line_cnt #(
   parameter int POS_W = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic hsync,
   output logic [POS_W-1:0] cnt,
   output logic step
);
   localparam logic [POS_W-1:0] TOP = '1;

   assign step = (cnt != TOP);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= TOP;
      else if (hsync)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/vpg_out_lane.sv
// One output: slot match, optional merge, toggle register.
module vpg_out_lane import vpg_pkg::*; #(
   parameter int NUM_PAT = 4,
   parameter int NUM_TOG = 4,
   parameter int POS_W = 12,
   parameter bit CONCAT_EN = 1'b1,
   localparam int PID_W = $clog2(NUM_PAT)
) (
   input  logic clk,
   input  logic rst,
   input  logic hsync,
   input  logic concat,
   input  logic [GSEL_W-1:0] gsel,
   input  logic [PID_W-1:0] slot_pat [SLOTS],
   input  logic [NUM_PAT-1:0] pol,
   input  logic [NUM_TOG-1:0][POS_W-1:0] pos [NUM_PAT],
   input  logic [POS_W-1:0] cnt,
   input  logic step,
   output logic vout
);
   logic [SLOTS-1:0] slot_hit;
   logic hit, start_pol;

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         slot_hit[s] = 1'b0;
         for (int t = 0; t < NUM_TOG; t++)
            if (pos[slot_pat[s]][t] == cnt)
               slot_hit[s] = 1'b1;
      end
   end

   if (CONCAT_EN) begin : g_cat
      always_comb begin
         hit       = concat ? (|slot_hit) : slot_hit[gsel];
         start_pol = concat ? pol[slot_pat[0]] : pol[slot_pat[gsel]];
      end
   end else begin : g_plain
      logic unused_cat;
      assign unused_cat = concat;
      always_comb begin
         hit       = slot_hit[gsel];
         start_pol = pol[slot_pat[gsel]];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         vout <= 1'b0;
      else if (hsync)
         vout <= start_pol;
      else if (step && hit)
         vout <= ~vout;
   end
endmodule

// File: rtl/vpg_group_sel.sv
module vpg_group_sel import vpg_pkg::*; #(
   parameter int NUM_OUT = 8,
   parameter int NUM_PAT = 4,
   parameter int NUM_TOG = 4,
   parameter int POS_W = 12,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter bit CONCAT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic hsync,
   input  logic wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_OUT-1:0] vout
);
   localparam int PID_W = $clog2(NUM_PAT);
   localparam int OUT_W = $clog2(NUM_OUT);
   localparam int K_W = $clog2(NUM_TOG + 1);

   if (NUM_OUT < 2 || NUM_OUT > 16) begin : g_bad_out
      $error("NUM_OUT must lie in 2..16");
   end
   if (NUM_PAT < 2) begin : g_bad_pat
      $error("NUM_PAT must be at least 2");
   end
   if (NUM_TOG < 2 || (NUM_TOG & (NUM_TOG - 1)) != 0) begin : g_bad_tog
      $error("NUM_TOG must be a power of two, at least 2");
   end
   if (DATA_W < POS_W || DATA_W < CAT_LSB + CAT_W) begin : g_bad_data
      $error("DATA_W too narrow for positions or merge field");
   end
   if (ADDR_W < 6 || ADDR_W < K_W + OUT_W + PID_W + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic v_concat;
   logic [PID_W-1:0] v_slot [SLOTS];
   logic [NUM_OUT-1:0][GSEL_W-1:0] v_gsel;
   logic [NUM_OUT-1:0] v_pol [NUM_PAT];
   logic [NUM_OUT-1:0][NUM_TOG-1:0][POS_W-1:0] v_pos [NUM_PAT];
   logic [POS_W-1:0] line_cnt;
   logic cnt_step;

   vpg_regs #(
      .NUM_OUT(NUM_OUT), .NUM_PAT(NUM_PAT), .NUM_TOG(NUM_TOG),
      .POS_W(POS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst(rst), .hsync(hsync),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .v_concat(v_concat), .v_slot(v_slot), .v_gsel(v_gsel),
      .v_pol(v_pol), .v_pos(v_pos)
   );

   vpg_line_cnt #(.POS_W(POS_W)) u_cnt (
      .clk(clk), .rst(rst), .hsync(hsync),
      .cnt(line_cnt), .step(cnt_step)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
      logic [NUM_TOG-1:0][POS_W-1:0] l_pos [NUM_PAT];
      logic [NUM_PAT-1:0] l_pol;
      for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
         assign l_pos[p] = v_pos[p][o];
         assign l_pol[p] = v_pol[p][o];
      end
      vpg_out_lane #(
         .NUM_PAT(NUM_PAT), .NUM_TOG(NUM_TOG), .POS_W(POS_W),
         .CONCAT_EN(CONCAT_EN)
      ) u_lane (
         .clk(clk), .rst(rst), .hsync(hsync), .concat(v_concat),
         .gsel(v_gsel[o]), .slot_pat(v_slot), .pol(l_pol), .pos(l_pos),
         .cnt(line_cnt), .step(cnt_step), .vout(vout[o])
      );
   end
endmodule

// File: rtl/vpg_chk.sv
module vpg_chk #(
   parameter int POS_W = 12,
   parameter int NUM_OUT = 8
) (
   input logic clk,
   input logic rst,
   input logic hsync,
   input logic [POS_W-1:0] cnt,
   input logic [NUM_OUT-1:0] vout,
   input logic v_concat
);
   localparam logic [POS_W-1:0] TOP = '1;

   // R7
   line_restart_chk: assert property (@(posedge clk) disable iff (rst)
      hsync |=> (cnt == '0));

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!hsync && cnt != TOP) |=> (cnt == POS_W'($past(cnt) + 1'b1)));

   // R10
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!hsync && cnt == TOP) |=> (cnt == TOP));

   // R10
   sat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!hsync && cnt == TOP) |=> $stable(vout));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !hsync |=> (hsync || $stable(v_concat)));
endmodule

bind vpg_group_sel vpg_chk #(.POS_W(POS_W), .NUM_OUT(NUM_OUT)) u_chk (
   .clk(clk), .rst(rst), .hsync(hsync), .cnt(line_cnt),
   .vout(vout), .v_concat(v_concat)
);

// File: tb/test_vpg_group_sel.sv
`timescale 1ns/1ps
module test_vpg_group_sel;
   localparam int NO = 8;
   localparam int NP = 4;
   localparam int NT = 4;
   localparam int TOPC = 4095;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hsync = 1'b0;
   logic wr_en = 1'b0;
   logic [9:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [NO-1:0] vout;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   string tag = "R1";

   bit m_pol_s [NP][NO];
   bit m_pol_a [NP][NO];
   int m_pos_s [NP][NO][NT];
   int m_pos_a [NP][NO][NT];
   int m_slot_s [4];
   int m_slot_a [4];
   int m_gs_s [NO];
   int m_gs_a [NO];
   bit m_cat_s, m_cat_a;
   int mk;
   bit started;

   always #4 clk = ~clk;

   vpg_group_sel i_vpg_group_sel (
      .clk(clk), .rst(rst), .hsync(hsync), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .vout(vout)
   );

   task automatic model_write(input logic [9:0] a, input logic [15:0] d);
      int k;
      if (a == 10'h000) m_cat_s = (d[13:10] == 4'd1);
      else if (a >= 10'h004 && a <= 10'h007) m_slot_s[a - 10'h004] = int'(d[1:0]);
      else if (a >= 10'h010 && a < 10'(16 + NO)) m_gs_s[a - 10'h010] = int'(d[1:0]);
      else if (a[9]) begin
         k = int'(a[2:0]);
         if (k == 0) m_pol_s[a[7:6]][a[5:3]] = d[0];
         else if (k <= NT) m_pos_s[a[7:6]][a[5:3]][k-1] = int'(d[11:0]);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         for (int p = 0; p < NP; p++)
            for (int o = 0; o < NO; o++) begin
               m_pol_s[p][o] = 0; m_pol_a[p][o] = 0;
               for (int t = 0; t < NT; t++) begin
                  m_pos_s[p][o][t] = 0; m_pos_a[p][o][t] = 0;
               end
            end
         for (int s = 0; s < 4; s++) begin m_slot_s[s] = 0; m_slot_a[s] = 0; end
         for (int o = 0; o < NO; o++) begin m_gs_s[o] = 0; m_gs_a[o] = 0; end
         m_cat_s = 0; m_cat_a = 0;
         mk = TOPC; started = 0;
      end else begin
         if (hsync) begin
            m_pol_a = m_pol_s; m_pos_a = m_pos_s; m_slot_a = m_slot_s;
            m_gs_a = m_gs_s; m_cat_a = m_cat_s;
            mk = 0; started = 1;
         end else if (mk < TOPC) mk++;
         if (wr_en) model_write(wr_addr, wr_data);
      end
   end

   // Level = start polarity, inverted once per distinct position below the count.
   function automatic bit exp_bit(int o);
      int q [16];
      int n;
      int s;
      bit par;
      bit dup;
      n = 0;
      if (!started) return 1'b0;
      if (m_cat_a) begin
         par = m_pol_a[m_slot_a[0]][o];
         for (int i = 0; i < 4; i++)
            for (int t = 0; t < NT; t++) begin q[n] = m_pos_a[m_slot_a[i]][o][t]; n++; end
      end else begin
         s = m_gs_a[o];
         par = m_pol_a[m_slot_a[s]][o];
         for (int t = 0; t < NT; t++) begin q[n] = m_pos_a[m_slot_a[s]][o][t]; n++; end
      end
      for (int i = 0; i < n; i++) begin
         if (q[i] < mk) begin
            dup = 0;
            for (int j = 0; j < i; j++) if (q[j] == q[i]) dup = 1;
            if (!dup) par = ~par;
         end
      end
      return par;
   endfunction

   task automatic check_out();
      logic [NO-1:0] e;
      for (int o = 0; o < NO; o++) e[o] = exp_bit(o);
      n_chk++;
      if (vout !== e) begin
         n_bad++;
         $display("FAIL %s: vout=%b expected %b (count %0d)", tag, vout, e, mk);
      end
   endtask

   task automatic step(input bit hs, input bit we, input logic [9:0] a, input logic [15:0] d);
      @(negedge clk);
      check_out();
      hsync = hs; wr_en = we; wr_addr = a; wr_data = d;
   endtask

   function automatic logic [9:0] pat_addr(int p, int o, int k);
      return 10'(32'h200 | (p << 6) | (o << 3) | k);
   endfunction

   task automatic wr(input logic [9:0] a, input logic [15:0] d);
      step(0, 1, a, d);
   endtask

   task automatic run_line(int len);
      step(1, 0, '0, '0);
      for (int c = 1; c < len; c++) step(0, 0, '0, '0);
   endtask

   task automatic rand_wr(output logic [9:0] a, output logic [15:0] d);
      int k;
      case ($urandom % 8)
         0: begin
            a = 10'h000;
            d = ($urandom % 3 == 0) ? (16'h0400 | (16'($urandom) & 16'hC3FF)) : 16'($urandom);
         end
         1: begin a = 10'(4 + $urandom % 4); d = 16'($urandom); end
         2: begin a = 10'(16 + $urandom % NO); d = 16'($urandom); end
         default: begin
            k = int'($urandom % 8);
            a = pat_addr(int'($urandom % NP), int'($urandom % NO), k);
            d = (k == 0) ? 16'($urandom) : (16'($urandom % 90) | (16'($urandom) & 16'hF000));
         end
      endcase
   endtask

   initial begin
      logic [9:0] ra;
      logic [15:0] rd;
      int len;
      void'($urandom(32'd4242));
      tag = "R1";
      repeat (3) step(0, 0, '0, '0);
      rst = 1'b0;
      repeat (3) step(0, 0, '0, '0);

      // R9 / R10: writes before the first sync leave the outputs low
      tag = "R10";
      for (int o = 0; o < NO; o++) begin
         wr(pat_addr(0, o, 1), 16'(3 + o));
         wr(pat_addr(0, o, 2), 16'(20 + 2 * o));
         wr(pat_addr(0, o, 0), 16'(o & 1));
         wr(pat_addr(1, o, 1), 16'(5));
      end
      for (int s = 1; s < 4; s++) wr(10'(4 + s), 16'd1);
      repeat (10) step(0, 0, '0, '0);

      // R1: untouched group selects follow slot A (pattern 0)
      tag = "R1";
      run_line(50);
      run_line(30);

      // R3: retarget slot A to pattern 1
      tag = "R3";
      wr(10'h004, 16'd1);
      run_line(10);
      run_line(20);

      // Random lines
      tag = "R2/R3/R4/R7/R8/R9";
      for (int ln = 0; ln < 120; ln++) begin
         len = 8 + int'($urandom % 60);
         for (int c = 0; c < len; c++) begin
            rand_wr(ra, rd);
            step(c == len - 1, ($urandom % 4) == 0, ra, rd);
         end
      end

      // R5: merge of four distinct patterns, group select ignored
      tag = "R5";
      for (int p = 0; p < NP; p++) begin
         wr(pat_addr(p, 0, 0), 16'(p == 0));
         for (int t = 0; t < NT; t++) wr(pat_addr(p, 0, t + 1), 16'(p * 12 + t * 3 + 1));
         wr(10'(4 + p), 16'(p));
      end
      wr(10'h010, 16'd2);
      wr(10'h000, 16'h0400);
      run_line(70);
      run_line(70);
      wr(10'h000, 16'h0C00);
      run_line(70);
      run_line(70);

      // R6: duplicated slots and equal positions inside one pattern
      tag = "R6";
      wr(10'h004, 16'd0);
      for (int s = 1; s < 4; s++) wr(10'(4 + s), 16'd1);
      wr(pat_addr(0, 0, 1), 16'd7);
      wr(pat_addr(0, 0, 2), 16'd7);
      wr(pat_addr(0, 0, 3), 16'd15);
      wr(pat_addr(0, 0, 4), 16'd30);
      wr(pat_addr(1, 0, 1), 16'd15);
      wr(10'h000, 16'h0400);
      run_line(50);
      run_line(50);

      // R10: saturation, position 4095 never fires
      tag = "R10";
      wr(10'h000, 16'h0000);
      wr(10'h004, 16'd3);
      for (int o = 0; o < NO; o++) wr(10'(16 + o), 16'd0);
      wr(pat_addr(3, 0, 0), 16'd0);
      wr(pat_addr(3, 0, 1), 16'd4094);
      wr(pat_addr(3, 0, 2), 16'd4095);
      wr(pat_addr(3, 0, 3), 16'd100);
      wr(pat_addr(3, 0, 4), 16'd100);
      run_line(4200);
      run_line(5);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run still going, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule